// File: doc/BRIEF.md
# Vector Saturating Narrow Unit

This unit takes a 128-bit source vector of wide lanes and turns each lane into a value of half its width. A value that does not fit in the narrow type is clamped to the nearest bound of that type rather than truncated. The narrow results are written into alternate half-width lanes of a 128-bit destination vector that arrives with the operation. Every other lane passes through from the incoming destination value unchanged. The result is a merged vector, so a pair of operations, one for the even lanes and one for the odd lanes, can pack two wide vectors into one narrow vector.

Each operation sets these controls:
- the lane size: 16-bit to 8-bit, or 32-bit to 16-bit.
- the signedness of the source and of the result, as two separate flags.
- placement in the even lanes or in the odd lanes.
- an optional byte-granular predicate that masks individual wide lanes.

The operation is registered. It is presented with a valid strobe, and the merged vector and a saturation indication appear on the following clock edge.

Top module: `sat_narrow_unit`

## Requirements
- R1: With size_i=0 the source is eight 16-bit lanes and each narrows to an 8-bit result; wide lane i occupies source bits [16i+15:16i].
- R2: With size_i=1 the source is four 32-bit lanes and each narrows to a 16-bit result; wide lane i occupies source bits [32i+31:32i].
- R3: Flags res_uns_i=0, src_uns_i=0 (signed to signed): the source is read as two's complement and clamped to the signed narrow range. In-range values pass unchanged.
- R4: Flags res_uns_i=1, src_uns_i=1 (unsigned to unsigned): values above the unsigned narrow maximum become all-ones.
- R5: Flags res_uns_i=1, src_uns_i=0 (signed to unsigned): negative values become 0, and values above the unsigned narrow maximum become all-ones.
- R6: Flags res_uns_i=0, src_uns_i=1 (unsigned to signed): values above the signed narrow maximum become that maximum.
- R7: With top_i=0, narrow result i is written to narrow lane 2i. With top_i=1 it is written to narrow lane 2i+1.
- R8: Every narrow lane that the operation does not write equals the matching lane of dst_i.
- R9: When pred_en_i=1, wide lane i is active only if predicate bit (i × wide lane bytes) is set, that is, bit 2i for 16-bit lanes and bit 4i for 32-bit lanes. The target lane of an inactive wide lane keeps its dst_i value. When pred_en_i=0 all lanes are active.
- R10: sat_o is 1 exactly when at least one active lane was clamped.
- R11: res_o, sat_o and valid_o update on the clock edge that samples valid_i=1. valid_o follows valid_i by one cycle. While valid_i=0, res_o and sat_o hold their values.
- R12: While rst_ni is low, res_o, sat_o and valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| dst_i | input | 128 | Incoming destination vector |
| src_i | input | 128 | Wide source vector |
| size_i | input | 1 | 0: 16 to 8 bits, 1: 32 to 16 bits |
| res_uns_i | input | 1 | Result is unsigned |
| src_uns_i | input | 1 | Source is unsigned |
| top_i | input | 1 | 0: even narrow lanes, 1: odd narrow lanes |
| pred_en_i | input | 1 | Apply predicate mask |
| pred_i | input | 16 | Per-byte predicate |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Merged result vector |
| sat_o | output | 1 | Some active lane was clamped |

## Verification
The bench builds the unit with its default 128-bit vector width, so the full 16-to-8 input space is small enough to enumerate. Every 16-bit source value is driven through each of the four flag codes, and the bench alternates placement between operations. The 32-to-16 path is swept with bound-adjacent values mixed with pseudo-random words, across every flag code and both placements. All 256 patterns of the predicate bits that matter are driven under both lane sizes, which exposes any confusion between the bytes a predicate bit selects.

// File: rtl/sat_narrow_pkg.sv
package sat_narrow_pkg;
  localparam int BYTE_W = 8;
  localparam int SMALL_WIDE_W = 16;
  localparam int LARGE_WIDE_W = 32;

  typedef enum logic [1:0] {
    MODE_SS = 2'b00,  // {res_uns, src_uns}
    MODE_SU = 2'b01,
    MODE_US = 2'b10,
    MODE_UU = 2'b11
  } sign_mode_e;
endpackage

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int WIDE_W = 16
) (
  input  logic [WIDE_W-1:0]   val_i,
  input  logic                res_uns_i,
  input  logic                src_uns_i,
  output logic [WIDE_W/2-1:0] val_o,
  output logic                sat_o
);
  localparam int NW = WIDE_W / 2;

  logic neg;

  always_comb begin
    neg   = !src_uns_i && val_i[WIDE_W-1];
    val_o = val_i[NW-1:0];
    sat_o = 1'b0;
    if (res_uns_i) begin
      if (neg) begin
        val_o = '0;
        sat_o = 1'b1;
      end else if (|val_i[WIDE_W-1:NW]) begin
        val_o = '1;
        sat_o = 1'b1;
      end
    end else if (neg) begin
      if (!(&val_i[WIDE_W-1:NW-1])) begin
        val_o = {1'b1, {(NW-1){1'b0}}};
        sat_o = 1'b1;
      end
    end else if (|val_i[WIDE_W-1:NW-1]) begin
      val_o = {1'b0, {(NW-1){1'b1}}};
      sat_o = 1'b1;
    end
  end

  // clamped unsigned results sit on a bound
  always_comb begin
    p_uns_bound_r5: assert (!(sat_o && res_uns_i) || val_o == '0 || &val_o);
    p_sgn_bound_r3: assert (!(sat_o && !res_uns_i) ||
                            val_o[NW-2:0] == {(NW-1){~val_o[NW-1]}});
  end
endmodule

// File: rtl/sat_lane_bank.sv
module sat_lane_bank #(
  parameter int VEC_W  = 128,
  parameter int WIDE_W = 16
) (
  input  logic [VEC_W-1:0]        src_i,
  input  logic                    res_uns_i,
  input  logic                    src_uns_i,
  output logic [VEC_W/2-1:0]      narrow_o,
  output logic [VEC_W/WIDE_W-1:0] sat_o
);
  localparam int LANES = VEC_W / WIDE_W;
  localparam int NW    = WIDE_W / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sat_clamp #(.WIDE_W(WIDE_W)) u_clamp (
      .val_i    (src_i[i*WIDE_W +: WIDE_W]),
      .res_uns_i(res_uns_i),
      .src_uns_i(src_uns_i),
      .val_o    (narrow_o[i*NW +: NW]),
      .sat_o    (sat_o[i])
    );
  end
endmodule

// File: rtl/sat_lane_merge.sv
module sat_lane_merge
  import sat_narrow_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]              dst_i,
  input  logic [VEC_W/2-1:0]            nar_s_i,
  input  logic [VEC_W/2-1:0]            nar_l_i,
  input  logic [VEC_W/SMALL_WIDE_W-1:0] act_s_i,
  input  logic [VEC_W/LARGE_WIDE_W-1:0] act_l_i,
  input  logic                          size_i,
  input  logic                          top_i,
  output logic [VEC_W-1:0]              res_o
);
  localparam int BYTES = VEC_W / BYTE_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam logic PAR_S = logic'(b % 2);
    localparam logic PAR_L = logic'((b / 2) % 2);
    logic wr_s, wr_l;
    assign wr_s = !size_i && (top_i == PAR_S) && act_s_i[b/2];
    assign wr_l =  size_i && (top_i == PAR_L) && act_l_i[b/4];
    always_comb begin
      if (wr_s)      res_o[b*BYTE_W +: BYTE_W] = nar_s_i[(b/2)*BYTE_W +: BYTE_W];
      else if (wr_l) res_o[b*BYTE_W +: BYTE_W] = nar_l_i[(b/4)*2*BYTE_W + (b%2)*BYTE_W +: BYTE_W];
      else           res_o[b*BYTE_W +: BYTE_W] = dst_i[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit
  import sat_narrow_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [VEC_W-1:0]       dst_i,
  input  logic [VEC_W-1:0]       src_i,
  input  logic                   size_i,
  input  logic                   res_uns_i,
  input  logic                   src_uns_i,
  input  logic                   top_i,
  input  logic                   pred_en_i,
  input  logic [VEC_W/8-1:0]     pred_i,
  output logic                   valid_o,
  output logic [VEC_W-1:0]       res_o,
  output logic                   sat_o
);
  localparam int LANES_S = VEC_W / SMALL_WIDE_W;
  localparam int LANES_L = VEC_W / LARGE_WIDE_W;
  localparam int STEP_S  = SMALL_WIDE_W / BYTE_W;
  localparam int STEP_L  = LARGE_WIDE_W / BYTE_W;
  localparam int BYTES   = VEC_W / BYTE_W;

  logic [VEC_W/2-1:0] nar_s, nar_l;
  logic [LANES_S-1:0] sat_s, act_s;
  logic [LANES_L-1:0] sat_l, act_l;
  logic [VEC_W-1:0]   merged;
  logic               sat_any;

  sat_lane_bank #(.VEC_W(VEC_W), .WIDE_W(SMALL_WIDE_W)) u_bank_s (
    .src_i(src_i), .res_uns_i(res_uns_i), .src_uns_i(src_uns_i),
    .narrow_o(nar_s), .sat_o(sat_s)
  );

  sat_lane_bank #(.VEC_W(VEC_W), .WIDE_W(LARGE_WIDE_W)) u_bank_l (
    .src_i(src_i), .res_uns_i(res_uns_i), .src_uns_i(src_uns_i),
    .narrow_o(nar_l), .sat_o(sat_l)
  );

  // lane active when predicate bit of its lowest byte is set
  for (genvar i = 0; i < LANES_S; i++) begin : g_act_s
    assign act_s[i] = !pred_en_i || pred_i[i*STEP_S];
  end
  for (genvar i = 0; i < LANES_L; i++) begin : g_act_l
    assign act_l[i] = !pred_en_i || pred_i[i*STEP_L];
  end

  sat_lane_merge #(.VEC_W(VEC_W)) u_merge (
    .dst_i(dst_i), .nar_s_i(nar_s), .nar_l_i(nar_l),
    .act_s_i(act_s), .act_l_i(act_l),
    .size_i(size_i), .top_i(top_i), .res_o(merged)
  );

  assign sat_any = size_i ? |(sat_l & act_l) : |(sat_s & act_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sat_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= merged;
        sat_o <= sat_any;
      end
    end
  end

  p_valid_pipe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(sat_o));

  p_pred_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pred_en_i && pred_i == '0 |=> res_o == $past(dst_i) && !sat_o);

  for (genvar b = 1; b < BYTES; b += 2) begin : g_keep_chk
    p_keep_odd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !size_i && !top_i |=>
        res_o[b*BYTE_W +: BYTE_W] == $past(dst_i[b*BYTE_W +: BYTE_W]));
  end
endmodule

// File: tb/sat_narrow_unit_tb_top.sv
module sat_narrow_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [127:0] dst_i = '0, src_i = '0;
  logic size_i = 1'b0, res_uns_i = 1'b0, src_uns_i = 1'b0, top_i = 1'b0, pred_en_i = 1'b0;
  logic [15:0] pred_i = '0;
  logic valid_o, sat_o;
  logic [127:0] res_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_narrow_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .dst_i(dst_i), .src_i(src_i),
    .size_i(size_i), .res_uns_i(res_uns_i), .src_uns_i(src_uns_i), .top_i(top_i),
    .pred_en_i(pred_en_i), .pred_i(pred_i), .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o)
  );

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  function automatic logic [127:0] rnd128();
    return {rnd(), rnd(), rnd(), rnd()};
  endfunction

  function automatic string mode_tag(input logic ru, input logic su);
    if (!ru && !su) return "R3";
    if (ru && su)   return "R4";
    if (ru)         return "R5";
    return "R6";
  endfunction

  // arithmetic reference: clamp each lane to the target range
  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] s,
      input logic sz, input logic ru, input logic su, input logic tp,
      input logic pe, input logic [15:0] pr, output logic sat);
    int ww, nh, n;
    logic [127:0] r;
    ww = sz ? 32 : 16;
    nh = ww / 2;
    n = 128 / ww;
    r = d;
    sat = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [127:0] t, m;
      longint v, lo, hi, c;
      int pos;
      t = s >> (i * ww);
      v = longint'(t[31:0]) & ((64'sd1 <<< ww) - 1);
      if (!su && v >= (64'sd1 <<< (ww - 1))) v = v - (64'sd1 <<< ww);
      lo = ru ? 64'sd0 : -(64'sd1 <<< (nh - 1));
      hi = ru ? ((64'sd1 <<< nh) - 1) : ((64'sd1 <<< (nh - 1)) - 1);
      c = (v < lo) ? lo : (v > hi) ? hi : v;
      if (!pe || pr[i * ww / 8]) begin
        pos = (2 * i + (tp ? 1 : 0)) * nh;
        m = ((128'd1 << nh) - 1);
        r = (r & ~(m << pos)) | ((128'(c) & m) << pos);
        if (c != v) sat = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic op(input logic [127:0] d, input logic [127:0] s, input logic sz,
      input logic ru, input logic su, input logic tp, input logic pe,
      input logic [15:0] pr, input string tag);
    logic [127:0] er;
    logic es;
    dst_i = d; src_i = s; size_i = sz; res_uns_i = ru; src_uns_i = su;
    top_i = tp; pred_en_i = pe; pred_i = pr; valid_i = 1'b1;
    er = model(d, s, sz, ru, su, tp, pe, pr, es);
    @(negedge clk);
    n_chk++;
    if (res_o !== er || !valid_o) begin
      n_fail++;
      $display("FAIL %s res: actual %h valid %b expected %h", tag, res_o, valid_o, er);
    end
    n_chk++;
    if (sat_o !== es) begin
      n_fail++;
      $display("FAIL R10 (%s) sat: actual %b expected %b", tag, sat_o, es);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    logic hs;
    repeat (3) @(negedge clk);
    // R12: reset state
    n_chk++;
    if (res_o !== '0 || sat_o !== 1'b0 || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset: actual %h/%b/%b expected 0/0/0", res_o, sat_o, valid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R1, R3-R8: exhaustive 16-bit lane values, each flag code, placement alternating
    for (int md = 0; md < 4; md++) begin
      for (int v = 0; v < 65536; v += 8) begin
        logic [127:0] s;
        logic tp;
        for (int k = 0; k < 8; k++) s[k*16 +: 16] = 16'(v + k);
        tp = logic'((v >> 3) & 1);
        op(rnd128(), s, 1'b0, logic'(md >> 1), logic'(md & 1), tp, 1'b0, 16'h0,
           {mode_tag(logic'(md >> 1), logic'(md & 1)), "_R1", tp ? "_R7" : "_R8"});
      end
    end

    // R2: 32-bit lanes with bound-adjacent values and random words
    for (int md = 0; md < 4; md++) begin
      for (int n = 0; n < 3000; n++) begin
        logic [127:0] s;
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
          w = rnd();
          case (w[3:0])
            4'd0: s[k*32 +: 32] = 32'h0000_7FFF;
            4'd1: s[k*32 +: 32] = 32'h0000_8000;
            4'd2: s[k*32 +: 32] = 32'h0000_FFFF;
            4'd3: s[k*32 +: 32] = 32'h0001_0000;
            4'd4: s[k*32 +: 32] = 32'hFFFF_8000;
            4'd5: s[k*32 +: 32] = 32'hFFFF_7FFF;
            4'd6: s[k*32 +: 32] = 32'h8000_0000;
            4'd7: s[k*32 +: 32] = 32'h7FFF_FFFF;
            4'd8: s[k*32 +: 32] = 32'hFFFF_FFFF;
            4'd9: s[k*32 +: 32] = 32'h0;
            4'd10: s[k*32 +: 32] = {16'h0, w[31:16]};
            4'd11: s[k*32 +: 32] = {16'hFFFF, w[31:16]};
            default: s[k*32 +: 32] = rnd();
          endcase
        end
        op(rnd128(), s, 1'b1, logic'(md >> 1), logic'(md & 1), logic'(n & 1), 1'b0, 16'h0,
           {mode_tag(logic'(md >> 1), logic'(md & 1)), "_R2", (n & 1) ? "_R7" : "_R8"});
      end
    end

    // R9: all patterns of the relevant predicate bits, both sizes; other bits random
    for (int sz = 0; sz < 2; sz++) begin
      for (int p = 0; p < 256; p++) begin
        logic [15:0] pr;
        logic [31:0] r;
        r = rnd();
        pr = r[15:0];
        if (sz == 0) for (int k = 0; k < 8; k++) pr[2*k] = p[k];
        else         for (int k = 0; k < 4; k++) pr[4*k] = p[k];
        op(rnd128(), rnd128(), logic'(sz), r[16], r[17], r[18], 1'b1, pr, "R9");
      end
    end

    // R10: fully masked lanes that would saturate report no saturation
    op(rnd128(), {8{16'h7FFF}}, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hAAAA, "R10_masked");
    op(rnd128(), {8{16'h7FFF}}, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0001, "R10_one");

    // R11: outputs hold while valid_i is low
    op(rnd128(), {4{32'h8000_0000}}, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R11_load");
    held = res_o;
    hs = sat_o;
    valid_i = 1'b0;
    dst_i = rnd128(); src_i = rnd128(); size_i = 1'b0;
    repeat (2) @(negedge clk);
    n_chk++;
    if (res_o !== held || sat_o !== hs || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 hold: actual %h/%b/%b expected %h/%b/0",
               res_o, sat_o, valid_o, held, hs);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule